// File: doc/BRIEF.md
# Fractional-Step Phase Accumulator

This block generates the running phase for a direct digital synthesizer. It keeps two accumulators. The fine accumulator is 12 bits wide and wraps at a programmable point. The coarse accumulator is 20 bits wide and wraps as a plain binary counter. Every enabled clock cycle, the fine step is added to the fine accumulator. When the fine sum reaches its wrap point (4096 minus the modulo input), the wrap point is subtracted and a carry of one enters the coarse accumulator. In the same cycle the coarse accumulator adds the coarse step and that carry.

The fine wrap point can be set to any value, not only a power of two. This lets the block step by exact rational fractions of a full cycle, such as 7/33, 8/11 or 9/13 of the clock rate, with no drift. With the modulo at zero the pair behaves as one 32-bit binary accumulator whose step is the 32-bit concatenation of coarse step (upper 20 bits) and fine step (lower 12 bits). A host can therefore load both steps with a single 32-bit write.

The phase output is the upper 19 bits of the coarse accumulator. It is intended to feed a sine/cosine generator.

Top module: `frac_phase_acc`

## Requirements
- R1: While `rst_n` is low, both accumulators are cleared asynchronously and `phase` reads 0.
- R2: On a clock edge where `en` is low, neither accumulator changes and `phase` holds its value.
- R3: `phase` equals bits 19 down to 1 of the coarse accumulator and has no extra register stage.
- R4: With `fine_mod` = 0, the concatenation {coarse, fine} advances by {`step_coarse`, `step_fine`} modulo 2^32 on each enabled edge.
- R5: On each enabled edge, if fine + `step_fine` >= 4096 − `fine_mod`, the fine accumulator becomes that sum minus (4096 − `fine_mod`) and the coarse accumulator receives an extra +1 in the same edge. Otherwise the fine accumulator takes the sum and no carry is made.
- R6: Steps chosen for k/N of a cycle, with 4096 − `fine_mod` a multiple of N, return `phase` exactly to 0 every N enabled cycles, over many periods.
- R7: A new step value takes effect on the next enabled edge and leaves the accumulated phase intact.
- R8: After reset, the first nonzero phase appears directly after the first enabled edge.
- R9: If the fine accumulator and `step_fine` are both below 4096 − `fine_mod`, the fine accumulator stays below it after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Advance enable |
| step_coarse | input | 20 | Coarse phase increment |
| step_fine | input | 12 | Fine phase increment |
| fine_mod | input | 12 | Amount by which the fine wrap point is lowered below 4096 |
| phase | output | 19 | Upper bits of the coarse accumulator |

## Verification
The bench builds the block with its default widths: a 20-bit coarse accumulator, a 12-bit fine accumulator and a 19-bit output. At these widths the 7/33, 8/11 and 9/13 settings can be expressed with fine wrap points of 4092 and 4095. This makes periodic return to zero observable across several full periods. The same widths also allow the modulo-zero case to be compared against a full 32-bit binary sum.

A tiny wrap point of 2 makes the carry path visible in the output within a few cycles. A near-maximal fine step with a wrap point of 4000 drives a carry on almost every cycle.

// File: rtl/frac_phase_pkg.sv
package frac_phase_pkg;
  localparam int unsigned COARSE_W_DEF = 20;
  localparam int unsigned FINE_W_DEF   = 12;
  localparam int unsigned PHASE_W_DEF  = 19;
endpackage

// File: rtl/fine_acc.sv
module fine_acc #(
  parameter int unsigned FINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FINE_W-1:0] step,
  input  logic [FINE_W-1:0] modv,
  output logic [FINE_W-1:0] acc,
  output logic              carry
);
  localparam logic [FINE_W:0] FULL = (FINE_W+1)'(1) << FINE_W;

  logic [FINE_W-1:0] acc_q;
  logic [FINE_W-1:0] acc_d;
  logic [FINE_W:0]   sum;
  logic [FINE_W:0]   limit;
  logic              wrap;

  always_comb begin
    limit = FULL - {1'b0, modv};
    sum   = {1'b0, acc_q} + {1'b0, step};
    wrap  = (sum >= limit);
    acc_d = acc_q;
    if (en) begin
      if (wrap) acc_d = FINE_W'(sum - limit);
      else      acc_d = sum[FINE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc   = acc_q;
  assign carry = en & wrap;

  // R9: residue stays in range when inputs are in range
  p_fine_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ({1'b0, acc_q} < limit) && ({1'b0, step} < limit))
      |=> ({1'b0, acc_q} < $past(limit)));

  // R2: fine side frozen when disabled
  p_fine_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/coarse_acc.sv
module coarse_acc #(
  parameter int unsigned COARSE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [COARSE_W-1:0] step,
  input  logic                carry_in,
  output logic [COARSE_W-1:0] acc
);
  logic [COARSE_W-1:0] acc_q;
  logic [COARSE_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + step + COARSE_W'(carry_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R2: coarse side frozen when disabled
  p_coarse_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));

  // R5: a lone carry with zero step bumps the coarse value by one
  p_carry_bump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && carry_in && step == '0) |=> (acc_q == $past(acc_q) + COARSE_W'(1)));
endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc
  import frac_phase_pkg::*;
#(
  parameter int unsigned COARSE_W = COARSE_W_DEF,
  parameter int unsigned FINE_W   = FINE_W_DEF,
  parameter int unsigned PHASE_W  = PHASE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [COARSE_W-1:0] step_coarse,
  input  logic [FINE_W-1:0]   step_fine,
  input  logic [FINE_W-1:0]   fine_mod,
  output logic [PHASE_W-1:0]  phase
);
  localparam int unsigned TOTAL_W = COARSE_W + FINE_W;

  logic [FINE_W-1:0]   fine_val;
  logic [COARSE_W-1:0] coarse_val;
  logic                fine_carry;

  fine_acc #(.FINE_W(FINE_W)) u_fine (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .step  (step_fine),
    .modv  (fine_mod),
    .acc   (fine_val),
    .carry (fine_carry)
  );

  coarse_acc #(.COARSE_W(COARSE_W)) u_coarse (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .step     (step_coarse),
    .carry_in (fine_carry),
    .acc      (coarse_val)
  );

  generate
    if (PHASE_W <= COARSE_W) begin : g_phase_slice
      assign phase = coarse_val[COARSE_W-1 -: PHASE_W];
    end else begin : g_phase_pad
      assign phase = {coarse_val, {(PHASE_W-COARSE_W){1'b0}}};
    end
  endgenerate

  // R4: with zero modulo the pair is one wide binary accumulator
  p_binary_equiv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fine_mod == '0) |=>
      ({coarse_val, fine_val} ==
       $past({coarse_val, fine_val}) + $past({step_coarse, step_fine})));

  // R8: the first enabled edge with nonzero step changes the output when
  // the step reaches the output bits
  p_first_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && coarse_val == '0 && fine_val == '0 && fine_mod == '0 &&
     step_coarse[COARSE_W-1 -: 2] == 2'b01)
      |=> (phase != '0));

  logic [TOTAL_W-1:0] unused_total;
  assign unused_total = '0;
endmodule

// File: tb/frac_phase_acc_tb.sv
module frac_phase_acc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [19:0] step_coarse = '0;
  logic [11:0] step_fine = '0;
  logic [11:0] fine_mod = '0;
  logic [18:0] phase;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  longint unsigned tot;
  longint unsigned mmod;
  longint unsigned sstep;

  always #4 clk = ~clk;

  frac_phase_acc u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .step_coarse(step_coarse), .step_fine(step_fine),
    .fine_mod(fine_mod), .phase(phase)
  );

  localparam int NV = 6;
  localparam int unsigned VH[NV]  = '{222425, 762600, 725937, 32'h12345, 0,    0};
  localparam int unsigned VL[NV]  = '{868,    2976,   945,    32'hABC,   3999, 1};
  localparam int unsigned VM[NV]  = '{4,      4,      1,      0,         96,   4094};
  localparam int unsigned VN[NV]  = '{165,    55,     65,     40,        50,   16};
  localparam int unsigned VP[NV]  = '{33,     11,     13,     0,         0,    0};

  task automatic check(input string req, input logic [18:0] exp);
    compared++;
    if (phase !== exp) begin
      mismatched++;
      $display("FAIL %s: phase=%0d expected=%0d at %0t", req, phase, exp, $time);
    end
  endtask

  function automatic logic [18:0] model_phase();
    return 19'((tot / mmod) >> 1);
  endfunction

  task automatic set_mode(input int unsigned h, input int unsigned l, input int unsigned m);
    step_coarse = 20'(h);
    step_fine   = 12'(l);
    fine_mod    = 12'(m);
    mmod  = 64'd4096 - m;
    sstep = longint'(h) * mmod + l;
  endtask

  task automatic tick(input bit e);
    en = e;
    @(posedge clk);
    if (e) tot = (tot + sstep) % (64'd1048576 * mmod);
    @(negedge clk);
  endtask

  task automatic do_reset();
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    tot = 0;
    check("R1", 19'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tot = 0; mmod = 4096; sstep = 0;
    repeat (3) @(negedge clk);
    check("R1", 19'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R3 R4 R5 R6 per step
    for (int v = 0; v < NV; v++) begin
      do_reset();
      set_mode(VH[v], VL[v], VM[v]);
      for (int c = 1; c <= int'(VN[v]); c++) begin
        tick(1'b1);
        check(VM[v] == 0 ? "R4" : "R5/R3", model_phase());
        if (VP[v] != 0 && (c % int'(VP[v])) == 0)
          check("R6", 19'd0);
      end
    end

    // R8: first enabled edge after reset shows motion
    do_reset();
    set_mode(32'h40000, 0, 0);
    tick(1'b0);
    check("R8", 19'd0);
    tick(1'b1);
    check("R8", 19'h20000);

    // R2: disabled edges hold the value
    set_mode(222425, 868, 4);
    tick(1'b1);
    begin
      logic [18:0] held;
      held = phase;
      for (int i = 0; i < 5; i++) begin
        tick(1'b0);
        check("R2", held);
      end
    end

    // R7: change step mid-run without clearing (same modulo)
    do_reset();
    set_mode(1000, 500, 4);
    for (int i = 0; i < 7; i++) tick(1'b1);
    check("R7", model_phase());
    set_mode(50000, 4000, 4);
    tick(1'b1);
    check("R7", model_phase());
    for (int i = 0; i < 6; i++) tick(1'b1);
    check("R7", model_phase());

    // R1: reset mid-run
    do_reset();
    check("R1", 19'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule